// File: doc/BRIEF.md
# Programmable-Resolution Watchdog Timer

This block supervises a host processor. Software writes one 8-bit control byte that sets a time-out. If the byte is not written again before that time-out runs out, the block raises a sticky watchdog flag. It can also drive an alarm output. Writing the byte again restarts the period at any time.

The time-out is the product of two fields of the byte. One is a five-bit multiplier. The other is a two-bit resolution code that picks a unit of 1/16 s, 1/4 s, 1 s or 4 s. Time is measured in pulses of a 16 Hz tick that the system supplies. A multiplier of zero turns the watchdog off.

Top module: `wdt_prog_timer`

## Requirements
- R1: After reset, the flag and the output are low and the watchdog is disabled, so no tick can cause a time-out until the control byte has been written.
- R2: A write with address 0x09 loads the control byte, with the multiplier in bits 6:2 and the resolution code in bits 1:0. Bit 7 is ignored. A write to any other address has no effect on the running count, the flag or the output.
- R3: Resolution code 00 makes one unit 1 tick, 01 makes it 4 ticks, 10 makes it 16 ticks and 11 makes it 64 ticks. The time-out is the multiplier times that many ticks, so the byte 0x0E expires on the 48th tick. The flag is high from the clock edge that samples the final tick.
- R4: Every write to the control byte restarts the period from zero, including the partial unit that was already counted.
- R5: A time-out sets the flag. The flag stays set while further ticks arrive.
- R6: A time-out raises the output only if the output enable input is high at that time-out. Otherwise the output stays low.
- R7: A write to the control byte clears both the output and the flag at the next clock edge.
- R8: A multiplier of zero disables the watchdog for any resolution code, so no time-out occurs however many ticks arrive.
- R9: The flag clear input clears the flag but leaves the output unchanged. If a clear and a time-out fall in the same cycle, the time-out wins.
- R10: A tick in the same cycle as a control write is not counted toward the new period.
- R11: After a time-out the watchdog stays idle until the next control write, so a cleared flag is not set again by later ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| tick_16hz | input | 1 | One-cycle pulse at 16 Hz |
| out_en | input | 1 | Allows a time-out to raise the output |
| flag_clr | input | 1 | Clears the sticky flag |
| wd_flag | output | 1 | Sticky time-out flag |
| wd_out | output | 1 | Time-out alarm output |

## Verification
The four resolution codes are each run with small and full-scale multipliers. Checking the flag one tick before and exactly at the expected tick tells the divide ratios apart, and it also catches an off-by-one error in either counter. Rewrites partway through a unit and partway through a period show whether the prescaler is also restarted, and writes to a neighbouring address show that the address is decoded. Clears, enables, ticks and writes that arrive in the same cycle as a time-out or a write test the priority rules. Long runs of ticks after a zero multiplier and after a time-out test the disabled and idle states.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int MULT_W = 5;
  localparam int RES_W  = 2;
  localparam int PRE_W  = 6;   // holds the largest divide ratio minus one
  localparam int DIV_W  = PRE_W + 1;

  typedef enum logic [RES_W-1:0] {
    RES_SIXTEENTH = 2'b00,
    RES_QUARTER   = 2'b01,
    RES_ONE       = 2'b10,
    RES_FOUR      = 2'b11
  } res_e;

  typedef struct packed {
    logic [MULT_W-1:0] mult;
    res_e              res;
  } wdt_cfg_t;

  // number of 16 Hz ticks in one unit of the selected resolution
  function automatic logic [DIV_W-1:0] ticks_per_unit(input res_e r);
    case (r)
      RES_SIXTEENTH: ticks_per_unit = DIV_W'(1);
      RES_QUARTER:   ticks_per_unit = DIV_W'(4);
      RES_ONE:       ticks_per_unit = DIV_W'(16);
      default:       ticks_per_unit = DIV_W'(64);
    endcase
  endfunction
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic tick_in,
  input  res_e res,
  output logic unit_tick
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [DIV_W-1:0] div_c;
  logic [PRE_W-1:0] last_c;

  always_comb begin
    div_c  = ticks_per_unit(res);
    last_c = PRE_W'(div_c - DIV_W'(1));
  end

  always_comb begin
    pre_d     = pre_q;
    unit_tick = 1'b0;
    if (restart) begin
      pre_d = '0;
    end else if (run && tick_in) begin
      if (pre_q == last_c) begin
        pre_d     = '0;
        unit_tick = 1'b1;
      end else begin
        pre_d = pre_q + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R3: partial unit never exceeds the selected divide ratio
  a_r3_pre_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= last_c)
    else $error("a_r3_pre_in_range");

  // R4: restart empties the partial unit
  a_r4_pre_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> pre_q == '0)
    else $error("a_r4_pre_restart");
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MULT_W-1:0] load_val,
  input  logic              step,
  output logic              armed,
  output logic              expire
);
  logic [MULT_W-1:0] remain_q, remain_d;

  always_comb begin
    remain_d = remain_q;
    if (load)
      remain_d = load_val;
    else if (step && remain_q != '0)
      remain_d = remain_q - MULT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remain_q <= '0;
    else        remain_q <= remain_d;
  end

  assign armed  = (remain_q != '0);
  assign expire = step && !load && (remain_q == MULT_W'(1));

  // R4: a write reloads the full multiplier
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> remain_q == $past(load_val))
    else $error("a_r4_reload");

  // R8/R11: an idle counter stays idle until the next write
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (remain_q == '0 && !load) |=> remain_q == '0)
    else $error("a_r11_idle_hold");

  // R3: each unit removes exactly one from the count
  a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && remain_q != '0) |=> remain_q == $past(remain_q) - MULT_W'(1))
    else $error("a_r3_one_step");
endmodule

// File: rtl/wdt_status.sv
module wdt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic expire,
  input  logic flag_clr,
  input  logic out_en,
  output logic flag,
  output logic out
);
  logic flag_q, flag_d;
  logic out_q, out_d;

  always_comb begin
    flag_d = flag_q;
    out_d  = out_q;
    if (wr_hit) begin
      flag_d = 1'b0;
      out_d  = 1'b0;
    end else if (expire) begin
      flag_d = 1'b1;
      if (out_en) out_d = 1'b1;
    end else if (flag_clr) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      out_q  <= out_d;
    end
  end

  assign flag = flag_q;
  assign out  = out_q;

  // R7: a control write drops both indications
  a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (!flag_q && !out_q))
    else $error("a_r7_write_clears");

  // R6: the output only rises at an enabled time-out
  a_r6_out_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> ($past(out_en) && $past(expire)))
    else $error("a_r6_out_gated");

  // R5: the flag holds until a clear or a write
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr && !wr_hit) |=> flag_q)
    else $error("a_r5_flag_sticky");

  // R9: clear leaves the output alone
  a_r9_clr_keeps_out: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !wr_hit) |=> out_q == $past(out_q) || out_q)
    else $error("a_r9_clr_keeps_out");
endmodule

// File: rtl/wdt_prog_timer.sv
module wdt_prog_timer
  import wdt_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h09
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              tick_16hz,
  input  logic              out_en,
  input  logic              flag_clr,
  output logic              wd_flag,
  output logic              wd_out
);
  localparam int CFG_W = MULT_W + RES_W;

  logic     srst_n;
  logic     wr_hit;
  wdt_cfg_t cfg_q, cfg_d;
  logic     armed, unit_tick, expire;

  wdt_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign wr_hit = wr_en && (wr_addr == CTL_ADDR);

  always_comb begin
    cfg_d = cfg_q;
    if (wr_hit) cfg_d = wdt_cfg_t'(wr_data[CFG_W-1:0]);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  wdt_prescaler u_pre (
    .clk       (clk),
    .rst_n     (srst_n),
    .run       (armed),
    .restart   (wr_hit),
    .tick_in   (tick_16hz),
    .res       (cfg_q.res),
    .unit_tick (unit_tick)
  );

  wdt_countdown u_cnt (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (wr_hit),
    .load_val (cfg_d.mult),
    .step     (unit_tick),
    .armed    (armed),
    .expire   (expire)
  );

  wdt_status u_sts (
    .clk      (clk),
    .rst_n    (srst_n),
    .wr_hit   (wr_hit),
    .expire   (expire),
    .flag_clr (flag_clr),
    .out_en   (out_en),
    .flag     (wd_flag),
    .out      (wd_out)
  );

  // R10: a tick in the write cycle never produces a unit
  a_r10_write_masks_tick: assert property (@(posedge clk) disable iff (!srst_n)
    wr_hit |-> !unit_tick)
    else $error("a_r10_write_masks_tick");

  // R8: no time-out while the count is idle
  a_r8_idle_no_expire: assert property (@(posedge clk) disable iff (!srst_n)
    !armed |-> !expire)
    else $error("a_r8_idle_no_expire");
endmodule

// File: tb/wdt_prog_timer_tb.sv
module wdt_prog_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic       clk, rst_n;
  logic       wr_en, tick_16hz, out_en, flag_clr;
  logic [7:0] wr_addr, wr_data;
  logic       wd_flag, wd_out;

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";
  bit    cmp_on = 0;
  bit    finished = 0;

  // behavioural reference state
  int m_mult, m_res, m_remain, m_pre;
  bit m_flag, m_out;

  wdt_prog_timer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .tick_16hz (tick_16hz),
    .out_en    (out_en),
    .flag_clr  (flag_clr),
    .wd_flag   (wd_flag),
    .wd_out    (wd_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int unit_len(int r);
    return 1 << (2 * r);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mult = 0; m_res = 0; m_remain = 0; m_pre = 0;
      m_flag = 0; m_out = 0;
    end else if (wr_en && wr_addr == 8'h09) begin
      m_mult   = int'(wr_data[6:2]);
      m_res    = int'(wr_data[1:0]);
      m_remain = m_mult;
      m_pre    = 0;
      m_flag   = 0;
      m_out    = 0;
    end else begin
      bit hit;
      hit = 0;
      if (tick_16hz && m_remain > 0) begin
        m_pre++;
        if (m_pre == unit_len(m_res)) begin
          m_pre = 0;
          if (m_remain == 1) hit = 1;
          m_remain--;
        end
      end
      if (hit) begin
        m_flag = 1;
        if (out_en) m_out = 1;
      end else if (flag_clr) begin
        m_flag = 0;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      chk(wd_flag == m_flag, cur_req, "flag vs model", int'(wd_flag), int'(m_flag));
      chk(wd_out == m_out, cur_req, "out vs model", int'(wd_out), int'(m_out));
    end
  end

  task automatic do_write(logic [7:0] a, logic [7:0] d, bit tk);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; tick_16hz = tk;
    @(negedge clk);
    wr_en = 0; wr_addr = 0; wr_data = 0; tick_16hz = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_16hz = 1;
      @(negedge clk);
      tick_16hz = 0;
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
    summary();
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    tick_16hz = 0; out_en = 1; flag_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cmp_on = 1;

    // R1: reset state, ticks before any write do nothing
    chk(wd_flag == 0, "R1", "flag after reset", int'(wd_flag), 0);
    chk(wd_out == 0, "R1", "out after reset", int'(wd_out), 0);
    ticks(70);
    chk(wd_flag == 0, "R1", "flag with no write", int'(wd_flag), 0);

    // R3/R5/R6: 0x0E -> 3 units of 16 ticks
    cur_req = "R3";
    do_write(8'h09, 8'h0E, 0);
    ticks(47);
    chk(wd_flag == 0, "R3", "flag at tick 47 of 48", int'(wd_flag), 0);
    ticks(1);
    chk(wd_flag == 1, "R5", "flag at tick 48", int'(wd_flag), 1);
    chk(wd_out == 1, "R6", "out at enabled time-out", int'(wd_out), 1);
    cur_req = "R5";
    ticks(100);
    chk(wd_flag == 1, "R5", "flag sticky", int'(wd_flag), 1);

    // R9: clear keeps out; R11: idle afterwards
    cur_req = "R9";
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
    chk(wd_flag == 0, "R9", "flag after clear", int'(wd_flag), 0);
    chk(wd_out == 1, "R9", "out after clear", int'(wd_out), 1);
    cur_req = "R11";
    ticks(200);
    chk(wd_flag == 0, "R11", "no second time-out", int'(wd_flag), 0);

    // R7 and R3 code 01: 0x05 -> 4 ticks
    cur_req = "R7";
    do_write(8'h09, 8'h05, 0);
    chk(wd_out == 0, "R7", "out after write", int'(wd_out), 0);
    cur_req = "R3";
    ticks(3);
    chk(wd_flag == 0, "R3", "code01 tick 3", int'(wd_flag), 0);
    ticks(1);
    chk(wd_flag == 1, "R3", "code01 tick 4", int'(wd_flag), 1);
    do_write(8'h09, 8'h05, 0);
    chk(wd_flag == 0, "R7", "flag after write", int'(wd_flag), 0);

    // R3 code 00: 0x14 -> 5 ticks; code 11: 0x07 -> 64; max 0x7C -> 31
    do_write(8'h09, 8'h14, 0);
    ticks(4);
    chk(wd_flag == 0, "R3", "code00 tick 4", int'(wd_flag), 0);
    ticks(1);
    chk(wd_flag == 1, "R3", "code00 tick 5", int'(wd_flag), 1);
    do_write(8'h09, 8'h07, 0);
    ticks(63);
    chk(wd_flag == 0, "R3", "code11 tick 63", int'(wd_flag), 0);
    ticks(1);
    chk(wd_flag == 1, "R3", "code11 tick 64", int'(wd_flag), 1);
    do_write(8'h09, 8'h7C, 0);
    ticks(30);
    chk(wd_flag == 0, "R3", "mult31 tick 30", int'(wd_flag), 0);
    ticks(1);
    chk(wd_flag == 1, "R3", "mult31 tick 31", int'(wd_flag), 1);

    // R4: restart mid-period and mid-unit
    cur_req = "R4";
    do_write(8'h09, 8'h09, 0);
    ticks(6);
    do_write(8'h09, 8'h09, 0);
    ticks(7);
    chk(wd_flag == 0, "R4", "restart mid-period", int'(wd_flag), 0);
    ticks(1);
    chk(wd_flag == 1, "R4", "expire after restart", int'(wd_flag), 1);
    do_write(8'h09, 8'h05, 0);
    ticks(3);
    do_write(8'h09, 8'h05, 0);
    ticks(3);
    chk(wd_flag == 0, "R4", "restart mid-unit", int'(wd_flag), 0);
    ticks(1);
    chk(wd_flag == 1, "R4", "unit restarted", int'(wd_flag), 1);

    // R2: other address ignored, bit 7 ignored
    cur_req = "R2";
    do_write(8'h09, 8'h0E, 0);
    ticks(40);
    do_write(8'h08, 8'h05, 0);
    ticks(7);
    chk(wd_flag == 0, "R2", "foreign write ignored 47", int'(wd_flag), 0);
    ticks(1);
    chk(wd_flag == 1, "R2", "foreign write ignored 48", int'(wd_flag), 1);
    do_write(8'h0A, 8'h00, 0);
    chk(wd_flag == 1, "R2", "foreign write keeps flag", int'(wd_flag), 1);
    do_write(8'h09, 8'h85, 0);
    ticks(3);
    chk(wd_flag == 0, "R2", "bit7 ignored tick 3", int'(wd_flag), 0);
    ticks(1);
    chk(wd_flag == 1, "R2", "bit7 ignored tick 4", int'(wd_flag), 1);

    // R8: zero multiplier disables
    cur_req = "R8";
    do_write(8'h09, 8'h00, 0);
    chk(wd_out == 0, "R8", "zero write clears out", int'(wd_out), 0);
    ticks(300);
    chk(wd_flag == 0, "R8", "all-zero disabled", int'(wd_flag), 0);
    do_write(8'h09, 8'h03, 0);
    ticks(200);
    chk(wd_flag == 0, "R8", "mult0 code11 disabled", int'(wd_flag), 0);

    // R6: output disabled by configuration
    cur_req = "R6";
    out_en = 0;
    do_write(8'h09, 8'h04, 0);
    ticks(1);
    chk(wd_flag == 1, "R6", "flag with out disabled", int'(wd_flag), 1);
    chk(wd_out == 0, "R6", "out stays low", int'(wd_out), 0);
    out_en = 1;

    // R9: time-out beats clear in the same cycle
    cur_req = "R9";
    do_write(8'h09, 8'h04, 0);
    @(negedge clk); tick_16hz = 1; flag_clr = 1;
    @(negedge clk); tick_16hz = 0; flag_clr = 0;
    chk(wd_flag == 1, "R9", "time-out wins over clear", int'(wd_flag), 1);

    // R10: tick in write cycle not counted
    cur_req = "R10";
    do_write(8'h09, 8'h04, 1);
    chk(wd_flag == 0, "R10", "write-cycle tick ignored", int'(wd_flag), 0);
    ticks(1);
    chk(wd_flag == 1, "R10", "first real tick expires", int'(wd_flag), 1);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule